// File: doc/BRIEF.md
# Three-Channel Status LED Controller

This block drives three indicator LEDs (red, green, yellow) from one 32-bit configuration word and a transmit-activity input. Each LED is given one of four behaviours by its own 2-bit mode field. It can be dark, lit steadily, toggling at a slow programmable rate, or flashing one on/off blink each time transmit activity is seen. All timing is counted in milliseconds. A shared prescaler turns the system clock into a 1 ms tick, and its clocks-per-millisecond count is a parameter.

Software writes the whole configuration word through a single write strobe. Each write restarts the prescaler and every channel's timing, so a new setting always starts from a known phase. A global polarity bit selects whether a lit LED drives its pin high or low.

Top module: `led_status_ctrl`

## Requirements
- R1: After reset, and again after any later reset, the configuration is all zero (every mode off, polarity active-low) and all three outputs are high.
- R2: When `cfg_we_i` is high at a clock edge, the word is stored and used from the next cycle. The write also restarts the millisecond prescaler and clears the timing state of all three channels, which then start dark.
- R3: Bit 30 is the polarity. When it is 1, a lit LED drives its output high. When it is 0, a lit LED drives its output low.
- R4: Mode 0 keeps the LED dark whatever `tx_act_i` does. Mode 3 keeps the LED lit.
- R5: In mode 1, `tx_act_i` high at an edge while the channel is idle lights the LED from that edge. It stays lit for the on-period (bits 7:0, in ms), then stays dark for the off-period (bits 15:8, in ms), and then the channel returns to idle.
- R6: In mode 1, activity that arrives during a blink, in either its lit or its dark phase, adds exactly one further blink after the current one. More activity in the same blink adds nothing more. Activity that arrives after the channel has gone idle starts a new blink.
- R7: In mode 2, the LED starts dark and toggles every slow-period milliseconds (bits 21:16). A slow-period of zero holds the LED dark.
- R8: The millisecond tick fires once every `CLKS_PER_MS` cycles, counted from the most recent write. In mode 1, a phase length of zero lasts one tick.
- R9: `led_o[0]` is red (mode bits 25:24), `led_o[1]` is green (bits 27:26) and `led_o[2]` is yellow (bits 29:28). Bits 31 and 23:22 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration word |
| tx_act_i | input | 1 | Transmit activity, sampled each cycle |
| led_o | output | 3 | LED outputs: [0] red, [1] green, [2] yellow |

## Verification
The bound checker watches, on every cycle, the relations that hold locally. These are: a write lands in the register, the steady modes hold their output level under either polarity, a slow blinker or an active blink phase changes only on a millisecond tick, and the tick never fires twice in a row. The exact lengths of the lit and dark phases, the single extension added by activity during a blink, and a fresh blink after idle all depend on counts over many ticks. Only the bench's timed scenarios show these. The same holds for zero-length periods and the restart on a write.

// File: rtl/led_ctrl_pkg.sv
package led_ctrl_pkg;
  localparam int LED_NUM = 3;
  localparam int MODE_W  = 2;
  localparam int ON_W    = 8;
  localparam int OFF_W   = 8;
  localparam int SLOW_W  = 6;
  localparam int CFG_W   = 32;

  typedef enum logic [MODE_W-1:0] {
    LED_OFF  = 2'd0,
    LED_ACT  = 2'd1,
    LED_SLOW = 2'd2,
    LED_ON   = 2'd3
  } mode_e;

  // bit layout is fixed by software view
  typedef struct packed {
    logic                             rsvd_hi;
    logic                             pol;
    logic [LED_NUM-1:0][MODE_W-1:0]   mode;
    logic [1:0]                       rsvd_mid;
    logic [SLOW_W-1:0]                slow_ms;
    logic [OFF_W-1:0]                 off_ms;
    logic [ON_W-1:0]                  on_ms;
  } cfg_t;
endpackage

// File: rtl/led_ms_tick.sv
module led_ms_tick #(
  parameter int CLKS_PER_MS = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  localparam int CNT_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_MS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST) && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clear_i)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/led_act_blink.sv
module led_act_blink
  import led_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             act_i,
  input  logic [ON_W-1:0]  on_ms_i,
  input  logic [OFF_W-1:0] off_ms_i,
  output logic             lit_o
);
  localparam int CW = (ON_W > OFF_W) ? ON_W : OFF_W;

  typedef enum logic [1:0] {ST_IDLE, ST_LIT, ST_DARK} st_e;

  st_e          st_q;
  logic [CW-1:0] cnt_q;
  logic         pend_q;
  logic [CW:0]  cnt_nxt;
  logic         on_done, off_done;

  assign cnt_nxt  = {1'b0, cnt_q} + 1'b1;
  // a zero length ends on the first tick
  assign on_done  = cnt_nxt >= (CW+1)'(on_ms_i);
  assign off_done = cnt_nxt >= (CW+1)'(off_ms_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; pend_q <= 1'b0;
    end else if (clear_i || !en_i) begin
      st_q <= ST_IDLE; cnt_q <= '0; pend_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (act_i) begin
          st_q <= ST_LIT; cnt_q <= '0; pend_q <= 1'b0;
        end
        ST_LIT: begin
          pend_q <= pend_q | act_i;
          if (tick_i) begin
            if (on_done) begin st_q <= ST_DARK; cnt_q <= '0; end
            else cnt_q <= cnt_nxt[CW-1:0];
          end
        end
        ST_DARK: begin
          pend_q <= pend_q | act_i;
          if (tick_i) begin
            if (off_done) begin
              cnt_q  <= '0;
              pend_q <= 1'b0;
              st_q   <= (pend_q || act_i) ? ST_LIT : ST_IDLE;
            end else cnt_q <= cnt_nxt[CW-1:0];
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign lit_o = (st_q == ST_LIT);
endmodule

// File: rtl/led_slow_blink.sv
module led_slow_blink
  import led_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [SLOW_W-1:0] slow_ms_i,
  output logic              lit_o
);
  logic [SLOW_W-1:0] cnt_q;
  logic              lit_q;
  logic [SLOW_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; lit_q <= 1'b0;
    end else if (clear_i || !en_i || (slow_ms_i == '0)) begin
      cnt_q <= '0; lit_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_nxt >= (SLOW_W+1)'(slow_ms_i)) begin
        cnt_q <= '0; lit_q <= ~lit_q;
      end else begin
        cnt_q <= cnt_nxt[SLOW_W-1:0];
      end
    end
  end

  assign lit_o = lit_q;
endmodule

// File: rtl/led_chan.sv
module led_chan
  import led_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              tick_i,
  input  logic              act_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pol_i,
  input  logic [ON_W-1:0]   on_ms_i,
  input  logic [OFF_W-1:0]  off_ms_i,
  input  logic [SLOW_W-1:0] slow_ms_i,
  output logic              lit_o,
  output logic              led_o
);
  logic act_lit, slow_lit;

  led_act_blink u_act (
    .clk_i, .rst_ni, .clear_i,
    .en_i     (mode_i == LED_ACT),
    .tick_i, .act_i, .on_ms_i, .off_ms_i,
    .lit_o    (act_lit)
  );

  led_slow_blink u_slow (
    .clk_i, .rst_ni, .clear_i,
    .en_i     (mode_i == LED_SLOW),
    .tick_i, .slow_ms_i,
    .lit_o    (slow_lit)
  );

  always_comb begin
    unique case (mode_i)
      LED_ACT:  lit_o = act_lit;
      LED_SLOW: lit_o = slow_lit;
      LED_ON:   lit_o = 1'b1;
      default:  lit_o = 1'b0;
    endcase
  end

  // pol=1: lit drives high
  assign led_o = pol_i ? lit_o : ~lit_o;
endmodule

// File: rtl/led_status_ctrl.sv
module led_status_ctrl
  import led_ctrl_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic               tx_act_i,
  output logic [LED_NUM-1:0] led_o
);
  cfg_t               cfg_q;
  logic               ms_tick;
  logic [LED_NUM-1:0] lit;
  logic               unused_rsvd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_t'(cfg_wdata_i);
  end

  assign unused_rsvd = ^{cfg_q.rsvd_hi, cfg_q.rsvd_mid};

  led_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk_i, .rst_ni,
    .clear_i (cfg_we_i),
    .tick_o  (ms_tick)
  );

  for (genvar g = 0; g < LED_NUM; g++) begin : g_chan
    led_chan u_chan (
      .clk_i, .rst_ni,
      .clear_i   (cfg_we_i),
      .tick_i    (ms_tick),
      .act_i     (tx_act_i),
      .mode_i    (cfg_q.mode[g]),
      .pol_i     (cfg_q.pol),
      .on_ms_i   (cfg_q.on_ms),
      .off_ms_i  (cfg_q.off_ms),
      .slow_ms_i (cfg_q.slow_ms),
      .lit_o     (lit[g]),
      .led_o     (led_o[g])
    );
  end
endmodule

// File: rtl/led_status_ctrl_chk.sv
module led_status_ctrl_chk
  import led_ctrl_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic [CFG_W-1:0]   cfg_wdata_i,
  input logic               tx_act_i,
  input logic [LED_NUM-1:0] led_o,
  input logic [CFG_W-1:0]   cfg_q,
  input logic               ms_tick,
  input logic [LED_NUM-1:0] lit
);
  cfg_t c;
  assign c = cfg_t'(cfg_q);

  assert_reset_dark_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (led_o == '1));

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cfg_q == $past(cfg_wdata_i)));

  assert_tick_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CLKS_PER_MS > 1 && ms_tick) |=> !ms_tick);

  for (genvar i = 0; i < LED_NUM; i++) begin : g_led
    assert_mode_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c.mode[i] == LED_ON) |-> (led_o[i] == c.pol));

    assert_mode_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c.mode[i] == LED_OFF) |-> (led_o[i] == !c.pol));

    assert_slow_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c.mode[i] == LED_SLOW && c.slow_ms == '0) |-> (led_o[i] == !c.pol));

    assert_slow_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c.mode[i] == LED_SLOW && !ms_tick && !cfg_we_i) |=> $stable(led_o[i]));

    assert_act_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c.mode[i] == LED_ACT && lit[i] && !ms_tick && !cfg_we_i) |=> lit[i]);
  end

  logic unused_chk;
  assign unused_chk = tx_act_i;
endmodule

bind led_status_ctrl led_status_ctrl_chk #(.CLKS_PER_MS(CLKS_PER_MS)) u_chk (
  .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .tx_act_i, .led_o,
  .cfg_q   (cfg_q),
  .ms_tick (ms_tick),
  .lit     (lit)
);

// File: tb/tb_led_status_ctrl.sv
module tb_led_status_ctrl;
  localparam int CPM = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic        tx_act_i = 1'b0;
  logic [2:0]  led_o;

  int total = 0;
  int bad   = 0;

  led_status_ctrl #(.CLKS_PER_MS(CPM)) dut (.*);

  always #10 clk_i = ~clk_i;

  typedef struct packed {
    logic [31:0] cfg;
    logic [7:0]  pa, pb, pc;   // activity cycles after the write, 0 = none
    logic [7:0]  n;            // sample after this many edges
    logic [2:0]  exp;          // {yellow, green, red}
    logic [3:0]  req;
  } vec_t;

  // A: on=2 off=3 slow=3, red act, green slow, yellow on, pol high
  localparam logic [31:0] A = 32'h7903_0302;
  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{A, 8'd1, 8'd0, 8'd0, 8'd2,  3'b101, 4'd5},  // R5 lit
    '{A, 8'd1, 8'd0, 8'd0, 8'd7,  3'b101, 4'd5},  // R5 still lit
    '{A, 8'd1, 8'd0, 8'd0, 8'd8,  3'b100, 4'd5},  // R5 dark after 2 ms
    '{A, 8'd0, 8'd0, 8'd0, 8'd11, 3'b100, 4'd7},  // R7
    '{A, 8'd0, 8'd0, 8'd0, 8'd12, 3'b110, 4'd7},  // R7 first toggle
    '{A, 8'd0, 8'd0, 8'd0, 8'd6,  3'b100, 4'd2},  // R2 write restarts green
    '{A, 8'd0, 8'd0, 8'd0, 8'd23, 3'b110, 4'd7},  // R7
    '{A, 8'd0, 8'd0, 8'd0, 8'd24, 3'b100, 4'd7},  // R7 second toggle
    '{A, 8'd1, 8'd5, 8'd0, 8'd20, 3'b111, 4'd6},  // R6 extension in lit phase
    '{A, 8'd1, 8'd5, 8'd0, 8'd27, 3'b101, 4'd6},  // R6
    '{A, 8'd1, 8'd5, 8'd0, 8'd28, 3'b100, 4'd6},  // R6 extension ends
    '{A, 8'd1, 8'd0, 8'd0, 8'd20, 3'b110, 4'd5},  // R5 idle after off phase
    '{A, 8'd1, 8'd10, 8'd0, 8'd21, 3'b111, 4'd6}, // R6 extension in dark phase
    '{A, 8'd1, 8'd22, 8'd0, 8'd27, 3'b101, 4'd6}, // R6 new blink after idle
    '{A, 8'd1, 8'd3, 8'd5, 8'd41, 3'b110, 4'd6},  // R6 only one extension
    '{32'h3903_0302, 8'd1, 8'd0, 8'd0, 8'd2, 3'b010, 4'd3}, // R3 active-low
    '{32'h4800_0000, 8'd0, 8'd0, 8'd0, 8'd30, 3'b000, 4'd7}, // R7 slow 0 dark
    '{32'h4000_0302, 8'd1, 8'd0, 8'd0, 8'd2, 3'b000, 4'd4},  // R4 off ignores act
    '{32'h3000_0000, 8'd0, 8'd0, 8'd0, 8'd5, 3'b011, 4'd4},  // R4 on, active-low
    '{32'h4400_0302, 8'd1, 8'd0, 8'd0, 8'd3, 3'b010, 4'd9},  // R9 green slot
    '{32'h5000_0302, 8'd1, 8'd0, 8'd0, 8'd2, 3'b100, 4'd9},  // R9 yellow slot
    '{32'h4100_0000, 8'd1, 8'd0, 8'd0, 8'd3, 3'b001, 4'd8},  // R8 zero on-time
    '{32'h4100_0000, 8'd1, 8'd0, 8'd0, 8'd4, 3'b000, 4'd8}   // R8 ends at 1 tick
  };

  task automatic check(input logic [2:0] exp, input string tag);
    total++;
    if (led_o !== exp) begin
      bad++;
      $display("FAIL %s: led_o=%b expected=%b", tag, led_o, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = v.cfg; tx_act_i = 1'b0;
    @(posedge clk_i);
    for (int k = 1; k <= int'(v.n); k++) begin
      @(negedge clk_i);
      cfg_we_i = 1'b0;
      tx_act_i = (k == int'(v.pa)) || (k == int'(v.pb)) || (k == int'(v.pc));
      @(posedge clk_i);
    end
    @(negedge clk_i);
    tx_act_i = 1'b0;
    check(v.exp, $sformatf("R%0d", v.req));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(3'b111, "R1 in reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(3'b111, "R1 after reset");

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R1: reset mid-run clears configuration
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = 32'h7000_0000;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    check(3'b100, "R4 yellow on before reset");
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(3'b111, "R1 reset mid-run");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule